// File: doc/BRIEF.md
# SPR Move Transfer Stage

This block is a purely combinational execution stage that carries out the two special-purpose-register moves. The first copies an SPR into a general register. The second copies a general register into an SPR. SPR storage is split across several places:

- a small flag file that holds the exception/status bits of XER;
- a fast SPR file;
- a slow SPR file, indexed by a 7-bit binary index;
- a 64-bit time base that can be read whole or as its upper half.

The stage never addresses a register port. It takes the data that has already been read and returns the result data with one valid flag per destination. The storage class and the slow index arrive already decoded. An opaque operation context passes straight through the stage.

For a read of XER, the stage builds the 64-bit value from the separate flag registers. For a write of XER, it splits the general-register value back into those flags.

Top module: `spr_move_stage`

## Requirements
- R1: Operation encoding on `op_kind`: 0 = idle, 1 = move from SPR, 2 = move to SPR, 3 = idle. An idle operation asserts no valid flag at all.
- R2: A move from SPR asserts `gpr_we` and no other valid flag.
- R3: A move from SPR with class 1 (XER) returns a 64-bit value with bit 31 = `xer_so_in`, bit 30 = `xer_ov_in[0]`, bit 29 = `xer_ca_in[0]`, bit 19 = `xer_ov_in[1]`, bit 18 = `xer_ca_in[1]`, and every other bit zero.
- R4: A move from SPR with class 2 (fast) returns `fast_rd`. With class 3 (slow) it returns `slow_rd`. With class 0, 6 or 7 it returns zero.
- R5: A move from SPR with class 4 returns the full `tb_in`. With class 5 it returns `tb_in[63:32]` zero-extended to 64 bits.
- R6: A move to SPR with class 1 drives `xer_so_out` = `gpr_in[31]`, `xer_ov_out` = {`gpr_in[19]`,`gpr_in[30]`} and `xer_ca_out` = {`gpr_in[18]`,`gpr_in[29]`}. It asserts `xer_so_we`, `xer_ov_we` and `xer_ca_we`.
- R7: A move to SPR with class 2 asserts `fast_we` with `fast_wd` = `gpr_in`. With class 3 it asserts `slow_we` with `slow_wd` = `gpr_in` and `slow_idx_out` = `slow_idx_in`.
- R8: `fast_we` and `slow_we` are never asserted together.
- R9: A move to SPR never asserts `gpr_we`. With a class other than 1, 2 or 3 it asserts no write-enable at all.
- R10: `ctx_out` equals `ctx_in` for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_kind | input | 2 | Operation selector |
| spr_class | input | 3 | Decoded SPR storage class |
| slow_idx_in | input | 7 | Decoded slow-file index |
| ctx_in | input | 16 | Operation context in |
| gpr_in | input | 64 | General-register operand |
| fast_rd | input | 64 | Fast SPR read data |
| slow_rd | input | 64 | Slow SPR read data |
| tb_in | input | 64 | Time base value |
| xer_so_in | input | 1 | Summary-overflow flag |
| xer_ov_in | input | 2 | Overflow flags {32-bit, 64-bit} |
| xer_ca_in | input | 2 | Carry flags {32-bit, 64-bit} |
| ctx_out | output | 16 | Operation context out |
| gpr_out | output | 64 | General-register result |
| gpr_we | output | 1 | General-register result valid |
| fast_wd | output | 64 | Fast SPR write data |
| fast_we | output | 1 | Fast SPR write valid |
| slow_wd | output | 64 | Slow SPR write data |
| slow_we | output | 1 | Slow SPR write valid |
| slow_idx_out | output | 7 | Slow-file write index |
| xer_so_out | output | 1 | Summary-overflow write value |
| xer_so_we | output | 1 | Summary-overflow write valid |
| xer_ov_out | output | 2 | Overflow write value |
| xer_ov_we | output | 1 | Overflow write valid |
| xer_ca_out | output | 2 | Carry write value |
| xer_ca_we | output | 1 | Carry write valid |

## Verification
The XER paths are tried with one-hot flag patterns. Each pattern lands one flag on one bit, so a swapped or misplaced bit shows up in both directions. The fast, slow and time-base reads use distinct data words on every source at the same time, so a wrong mux arm returns a value that cannot be mistaken for the expected one. The time base carries different upper and lower halves, which separates the full read from the upper-half read. Idle operations, unknown classes and moves to the time base are used to confirm that no stray write-enable or result-valid appears.

// File: rtl/spr_move_pkg.sv
package spr_move_pkg;
  localparam int XLEN   = 64;
  localparam int CTX_W  = 16;
  localparam int IDX_W  = 7;
  localparam int HALF   = XLEN / 2;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_MFS  = 2'd1,
    OP_MTS  = 2'd2,
    OP_RSVD = 2'd3
  } op_kind_t;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_XER  = 3'd1,
    CLS_FAST = 3'd2,
    CLS_SLOW = 3'd3,
    CLS_TB   = 3'd4,
    CLS_TBU  = 3'd5
  } spr_class_t;

  localparam int XB_SO   = 31;
  localparam int XB_OV   = 30;
  localparam int XB_CA   = 29;
  localparam int XB_OV32 = 19;
  localparam int XB_CA32 = 18;
endpackage

// File: rtl/spr_move_xer_fmt.sv
module spr_move_xer_fmt
  import spr_move_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         so_in,
  input  logic [1:0]   ov_in,
  input  logic [1:0]   ca_in,
  output logic [W-1:0] packed_out,
  input  logic [W-1:0] word_in,
  output logic         so_out,
  output logic [1:0]   ov_out,
  output logic [1:0]   ca_out
);
  always_comb begin
    packed_out          = '0;
    packed_out[XB_SO]   = so_in;
    packed_out[XB_OV]   = ov_in[0];
    packed_out[XB_CA]   = ca_in[0];
    packed_out[XB_OV32] = ov_in[1];
    packed_out[XB_CA32] = ca_in[1];
  end

  always_comb begin
    so_out = word_in[XB_SO];
    ov_out = {word_in[XB_OV32], word_in[XB_OV]};
    ca_out = {word_in[XB_CA32], word_in[XB_CA]};
  end
endmodule

// File: rtl/spr_move_read_mux.sv
module spr_move_read_mux
  import spr_move_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [2:0]   cls,
  input  logic [W-1:0] xer_word,
  input  logic [W-1:0] fast_rd,
  input  logic [W-1:0] slow_rd,
  input  logic [W-1:0] tb_in,
  output logic [W-1:0] result
);
  localparam int H = W / 2;

  always_comb begin
    unique case (cls)
      CLS_XER:  result = xer_word;
      CLS_FAST: result = fast_rd;
      CLS_SLOW: result = slow_rd;
      CLS_TB:   result = tb_in;
      CLS_TBU:  result = {{(W-H){1'b0}}, tb_in[W-1:H]};
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/spr_move_write_route.sv
module spr_move_write_route
  import spr_move_pkg::*;
(
  input  logic [1:0] op,
  input  logic [2:0] cls,
  output logic       gpr_we,
  output logic       fast_we,
  output logic       slow_we,
  output logic       xer_we
);
  logic is_mfs, is_mts;

  always_comb begin
    is_mfs  = (op == OP_MFS);
    is_mts  = (op == OP_MTS);
    gpr_we  = is_mfs;
    fast_we = is_mts && (cls == CLS_FAST);
    slow_we = is_mts && (cls == CLS_SLOW);
    xer_we  = is_mts && (cls == CLS_XER);
  end
endmodule

// File: rtl/spr_move_stage.sv
module spr_move_stage
  import spr_move_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int CW  = CTX_W,
  parameter int IW  = IDX_W
) (
  input  logic [1:0]    op_kind,
  input  logic [2:0]    spr_class,
  input  logic [IW-1:0] slow_idx_in,
  input  logic [CW-1:0] ctx_in,
  input  logic [W-1:0]  gpr_in,
  input  logic [W-1:0]  fast_rd,
  input  logic [W-1:0]  slow_rd,
  input  logic [W-1:0]  tb_in,
  input  logic          xer_so_in,
  input  logic [1:0]    xer_ov_in,
  input  logic [1:0]    xer_ca_in,
  output logic [CW-1:0] ctx_out,
  output logic [W-1:0]  gpr_out,
  output logic          gpr_we,
  output logic [W-1:0]  fast_wd,
  output logic          fast_we,
  output logic [W-1:0]  slow_wd,
  output logic          slow_we,
  output logic [IW-1:0] slow_idx_out,
  output logic          xer_so_out,
  output logic          xer_so_we,
  output logic [1:0]    xer_ov_out,
  output logic          xer_ov_we,
  output logic [1:0]    xer_ca_out,
  output logic          xer_ca_we
);
  logic [W-1:0] xer_word;
  logic         xer_we;

  spr_move_xer_fmt #(.W(W)) u_xer (
    .so_in      (xer_so_in),
    .ov_in      (xer_ov_in),
    .ca_in      (xer_ca_in),
    .packed_out (xer_word),
    .word_in    (gpr_in),
    .so_out     (xer_so_out),
    .ov_out     (xer_ov_out),
    .ca_out     (xer_ca_out)
  );

  spr_move_read_mux #(.W(W)) u_rd (
    .cls      (spr_class),
    .xer_word (xer_word),
    .fast_rd  (fast_rd),
    .slow_rd  (slow_rd),
    .tb_in    (tb_in),
    .result   (gpr_out)
  );

  spr_move_write_route u_wr (
    .op      (op_kind),
    .cls     (spr_class),
    .gpr_we  (gpr_we),
    .fast_we (fast_we),
    .slow_we (slow_we),
    .xer_we  (xer_we)
  );

  assign ctx_out      = ctx_in;
  assign fast_wd      = gpr_in;
  assign slow_wd      = gpr_in;
  assign slow_idx_out = slow_idx_in;
  assign xer_so_we    = xer_we;
  assign xer_ov_we    = xer_we;
  assign xer_ca_we    = xer_we;
endmodule

// File: rtl/spr_move_stage_chk.sv
module spr_move_stage_chk (
  input logic [1:0]  op_kind,
  input logic [2:0]  spr_class,
  input logic [63:0] gpr_in,
  input logic        xer_so_in,
  input logic [1:0]  xer_ov_in,
  input logic [1:0]  xer_ca_in,
  input logic [63:0] gpr_out,
  input logic        gpr_we,
  input logic        fast_we,
  input logic        slow_we,
  input logic        xer_so_we,
  input logic        xer_ov_we,
  input logic        xer_ca_we,
  input logic        xer_so_out
);
  always_comb begin
    assert_fast_slow_excl_R8: assert (!(fast_we && slow_we));
    assert_mts_no_gpr_R9: assert (!(op_kind == 2'd2 && gpr_we));
    assert_mfs_only_gpr_R2: assert (!(op_kind == 2'd1) ||
      (gpr_we && !fast_we && !slow_we && !xer_so_we && !xer_ov_we && !xer_ca_we));
    assert_idle_quiet_R1: assert (op_kind == 2'd1 || op_kind == 2'd2 ||
      !(gpr_we || fast_we || slow_we || xer_so_we || xer_ov_we || xer_ca_we));
    assert_xer_read_R3: assert (!(op_kind == 2'd1 && spr_class == 3'd1) ||
      (gpr_out[31] == xer_so_in && gpr_out[30] == xer_ov_in[0] &&
       gpr_out[29] == xer_ca_in[0] && gpr_out[19] == xer_ov_in[1] &&
       gpr_out[18] == xer_ca_in[1]));
    assert_xer_write_R6: assert (!xer_so_we || xer_so_out == gpr_in[31]);
    assert_unknown_no_we_R9: assert (!(op_kind == 2'd2 && spr_class > 3'd3) ||
      !(fast_we || slow_we || xer_so_we || xer_ov_we || xer_ca_we));
  end
endmodule

bind spr_move_stage spr_move_stage_chk u_chk (
  .op_kind    (op_kind),
  .spr_class  (spr_class),
  .gpr_in     (gpr_in),
  .xer_so_in  (xer_so_in),
  .xer_ov_in  (xer_ov_in),
  .xer_ca_in  (xer_ca_in),
  .gpr_out    (gpr_out),
  .gpr_we     (gpr_we),
  .fast_we    (fast_we),
  .slow_we    (slow_we),
  .xer_so_we  (xer_so_we),
  .xer_ov_we  (xer_ov_we),
  .xer_ca_we  (xer_ca_we),
  .xer_so_out (xer_so_out)
);

// File: tb/spr_move_stage_test.sv
`timescale 1ns/1ps
module spr_move_stage_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  op_kind;
  logic [2:0]  spr_class;
  logic [6:0]  slow_idx_in, slow_idx_out;
  logic [15:0] ctx_in, ctx_out;
  logic [63:0] gpr_in, fast_rd, slow_rd, tb_in;
  logic        xer_so_in;
  logic [1:0]  xer_ov_in, xer_ca_in;
  logic [63:0] gpr_out, fast_wd, slow_wd;
  logic        gpr_we, fast_we, slow_we;
  logic        xer_so_out, xer_so_we, xer_ov_we, xer_ca_we;
  logic [1:0]  xer_ov_out, xer_ca_out;

  int checks = 0;
  int fails  = 0;

  spr_move_stage uut (.*);

  localparam logic [63:0] FAST_V = 64'hF00D_0000_1111_2222;
  localparam logic [63:0] SLOW_V = 64'h5100_3333_4444_5555;
  localparam logic [63:0] TB_V   = 64'h89AB_CDEF_0123_4567;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [2:0] cls, input logic [63:0] g);
    @(negedge clk);
    op_kind = op; spr_class = cls; gpr_in = g;
    fast_rd = FAST_V; slow_rd = SLOW_V; tb_in = TB_V;
    @(posedge clk); #1;
  endtask

  function automatic logic [5:0] wes();
    return {gpr_we, fast_we, slow_we, xer_so_we, xer_ov_we, xer_ca_we};
  endfunction

  task automatic t_idle();
    apply(2'd0, 3'd2, 64'hFFFF);
    chk("R1 idle op0 valids", {58'd0, wes()}, 64'd0);
    apply(2'd3, 3'd1, 64'hFFFF);
    chk("R1 idle op3 valids", {58'd0, wes()}, 64'd0);
  endtask

  task automatic t_mfs_xer();
    xer_so_in = 1; xer_ov_in = 2'b00; xer_ca_in = 2'b00;
    apply(2'd1, 3'd1, 64'd0);
    chk("R3 so bit31", gpr_out, 64'h8000_0000);
    chk("R2 only gpr_we", {58'd0, wes()}, 64'b100000);
    xer_so_in = 0; xer_ov_in = 2'b01; xer_ca_in = 2'b10;
    apply(2'd1, 3'd1, 64'd0);
    chk("R3 ov bit30 ca32 bit18", gpr_out, 64'h4004_0000);
    xer_ov_in = 2'b10; xer_ca_in = 2'b01;
    apply(2'd1, 3'd1, 64'd0);
    chk("R3 ov32 bit19 ca bit29", gpr_out, 64'h2008_0000);
  endtask

  task automatic t_mfs_files();
    apply(2'd1, 3'd2, 64'd0);
    chk("R4 fast read", gpr_out, FAST_V);
    apply(2'd1, 3'd3, 64'd0);
    chk("R4 slow read", gpr_out, SLOW_V);
    chk("R2 slow read valids", {58'd0, wes()}, 64'b100000);
    apply(2'd1, 3'd7, 64'd0);
    chk("R4 unknown read zero", gpr_out, 64'd0);
  endtask

  task automatic t_tb();
    apply(2'd1, 3'd4, 64'd0);
    chk("R5 tb full", gpr_out, TB_V);
    apply(2'd1, 3'd5, 64'd0);
    chk("R5 tbu upper", gpr_out, 64'h0000_0000_89AB_CDEF);
  endtask

  task automatic t_mts_xer();
    apply(2'd2, 3'd1, 64'h0000_0000_A008_0000);
    chk("R6 so", {63'd0, xer_so_out}, 64'd1);
    chk("R6 ov", {62'd0, xer_ov_out}, 64'b10);
    chk("R6 ca", {62'd0, xer_ca_out}, 64'b01);
    chk("R6 xer we", {58'd0, wes()}, 64'b000111);
    apply(2'd2, 3'd1, 64'h0000_0000_4004_0000);
    chk("R6 ov/ca32", {60'd0, xer_ov_out, xer_ca_out}, 64'b0110);
  endtask

  task automatic t_mts_files();
    slow_idx_in = 7'd69;
    apply(2'd2, 3'd2, 64'hDEAD_BEEF_0000_0001);
    chk("R7 fast we", {58'd0, wes()}, 64'b010000);
    chk("R7 fast wd", fast_wd, 64'hDEAD_BEEF_0000_0001);
    chk("R8 fast not slow", {63'd0, fast_we & slow_we}, 64'd0);
    apply(2'd2, 3'd3, 64'h1234_5678_9ABC_DEF0);
    chk("R7 slow we", {58'd0, wes()}, 64'b001000);
    chk("R7 slow wd", slow_wd, 64'h1234_5678_9ABC_DEF0);
    chk("R7 slow idx", {57'd0, slow_idx_out}, 64'd69);
  endtask

  task automatic t_mts_other();
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 3) continue;
      apply(2'd2, c[2:0], 64'hFFFF_FFFF_FFFF_FFFF);
      chk($sformatf("R9 class %0d no we", c), {58'd0, wes()}, 64'd0);
    end
  endtask

  task automatic t_ctx();
    ctx_in = 16'hA5C3;
    apply(2'd1, 3'd2, 64'd0);
    chk("R10 ctx mfs", {48'd0, ctx_out}, 64'hA5C3);
    ctx_in = 16'h0F0F;
    apply(2'd2, 3'd3, 64'd0);
    chk("R10 ctx mts", {48'd0, ctx_out}, 64'h0F0F);
  endtask

  initial begin
    op_kind = 0; spr_class = 0; slow_idx_in = 0; ctx_in = 0; gpr_in = 0;
    fast_rd = 0; slow_rd = 0; tb_in = 0;
    xer_so_in = 0; xer_ov_in = 0; xer_ca_in = 0;
    repeat (2) @(posedge clk); #1;
    chk("R1 initial idle valids", {58'd0, wes()}, 64'd0);
    t_idle();
    t_mfs_xer();
    t_mfs_files();
    t_tb();
    t_mts_xer();
    t_mts_files();
    t_mts_other();
    t_ctx();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule